// File: doc/BRIEF.md
# SPI Command and Status Front-End

This block is the host-facing edge of a message record/playback controller. A host talks to it over a four-wire SPI link in mode 0: data is sampled on the rising edge of the serial clock and changed on the falling edge. Every transfer starts with an opcode byte. While that opcode is clocked in, the block clocks out its 8-bit status word, so the host always sees a fresh status without sending a separate request. The serial pins are oversampled by the system clock through synchronizer stages, so the whole block runs in a single clock domain.

The block sorts each opcode into one of three groups. Some are handled locally: read status, read and clear the interrupt flags, power up and power down. Some are forwarded to a command executor as a one-cycle strobe, and any operand bytes that follow go out as one-cycle strobes of their own. The rest are rejected. A power-down state limits which opcodes take effect. The block owns the interrupt flag register and drives an active-low, open-drain style interrupt request. It also provides a ready/busy output that the host consults before streaming data bytes.

Top module: `hostcmd_front`

## Requirements
- R1: SPI mode 0, bytes MSB first, with `spi_cs_n` low framing one transaction. The first byte is the opcode. When it is a forwarded opcode (0x2A, 0xAE, 0xAA, 0xC0) and the block is powered up, `cmd_valid_o` pulses for one cycle with `cmd_op_o` holding the opcode.
- R2: The status word shifts out on `spi_miso`, MSB first, during every byte except the flag byte of a read-interrupt transfer. Its bits, from 7 down to 0, are: powered-down, data-buffer-ready (`sink_ready_i` while powered up), any-flag-pending, `st_full_i`, constant 0, `st_vg_busy_i`, `st_cbuf_full_i`, `exec_busy_i`.
- R3: After reset the block is powered down, all flags are clear and `irq_n_o` is high (released). The status word therefore reads 0x80 when all status inputs are low.
- R4: While powered down, only 0x40 (read status), 0x46 (read interrupt) and 0x10 (power up) take effect. Every other opcode and its operands are dropped: nothing is forwarded and no flag is raised. The data-buffer-ready status bit reads 0 during power-down.
- R5: Opcode 0x10 while powered down clears the power-down state and sets the finished flag. Opcode 0x10 while powered up sets the error flag. Opcode 0x12 while powered up enters power-down and sets the finished flag.
- R6: Any opcode outside the decoded set, received while powered up, sets the error flag and forwards nothing.
- R7: A 0x46 transfer returns, as its second byte, a snapshot of the flag register taken when the opcode byte completed. Bit 0 of the flag register is finished, bit 1 is error, bit 2 is overflow. The flags in that snapshot are cleared when the second byte completes. A flag raised after the snapshot was taken stays set.
- R8: Flags are cleared only by R7. Any number of further status reads or commands leaves a set flag set.
- R9: `rdy_o` follows `sink_ready_i`. An operand byte of a forwarded opcode pulses `opnd_valid_o` only when the sink is ready; otherwise it is dropped. A dropped operand of a streaming opcode (0xAA or 0xC0) sets the overflow flag.
- R10: A pulse on `exec_done_i` sets the finished flag.
- R11: `irq_n_o` is low exactly while at least one flag selected by the `IRQ_MASK` parameter is set. The default mask selects bits 0 to 2.
- R12: Raising `spi_cs_n` in the middle of a byte throws away the partial byte. The next transaction starts again from its opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status/flag data to the host |
| rdy_o | output | 1 | High when the next data byte can be taken |
| irq_n_o | output | 1 | Interrupt request; 0 = pull low, 1 = released |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted forwarded opcode |
| cmd_op_o | output | 8 | Opcode qualified by `cmd_valid_o` |
| opnd_valid_o | output | 1 | One-cycle strobe for an accepted operand byte |
| opnd_data_o | output | 8 | Operand byte qualified by `opnd_valid_o` |
| sink_ready_i | input | 1 | The executor can take another data byte |
| exec_done_i | input | 1 | The executor finished a forwarded command |
| exec_busy_i | input | 1 | The executor is running a command |
| st_full_i | input | 1 | Memory-full status |
| st_vg_busy_i | input | 1 | Voice generator busy status |
| st_cbuf_full_i | input | 1 | Command buffer full status |

## Verification
The hardest case to reach is a flag that is raised between the snapshot taken at the read-interrupt opcode and the clear that follows the flag byte. That flag must survive the clear. The stimulus holds the select low after the opcode byte, pulses `exec_done_i` while the serial clock is idle, and only then clocks the flag byte. It then checks the returned byte and the state of the interrupt line. Constrained-random opcode sequences, with random sink readiness, run against a bench model of the power state and flags. They cover the power-down filtering, and in particular silent drops that would otherwise go unnoticed. A select raised partway through a byte is driven directly.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_RD_STATUS = 8'h40;
  localparam logic [BYTE_W-1:0] OP_RD_INT    = 8'h46;
  localparam logic [BYTE_W-1:0] OP_PWR_UP    = 8'h10;
  localparam logic [BYTE_W-1:0] OP_PWR_DN    = 8'h12;
  localparam logic [BYTE_W-1:0] OP_STOP      = 8'h2A;
  localparam logic [BYTE_W-1:0] OP_PLAY_IDX  = 8'hAE;
  localparam logic [BYTE_W-1:0] OP_PCM_WR    = 8'hAA;
  localparam logic [BYTE_W-1:0] OP_ENC_WR    = 8'hC0;

  localparam int FLAG_FIN = 0;
  localparam int FLAG_ERR = 1;
  localparam int FLAG_OVF = 2;

  typedef enum logic [1:0] {CTX_NONE, CTX_FWD, CTX_RDINT} ctx_e;
  typedef enum logic [2:0] {
    OPK_STATUS, OPK_RDINT, OPK_PUP, OPK_PDN, OPK_FWD, OPK_STREAM, OPK_BAD
  } opk_e;

  function automatic opk_e classify(input logic [BYTE_W-1:0] op);
    case (op)
      OP_RD_STATUS:         return OPK_STATUS;
      OP_RD_INT:            return OPK_RDINT;
      OP_PWR_UP:            return OPK_PUP;
      OP_PWR_DN:            return OPK_PDN;
      OP_STOP, OP_PLAY_IDX: return OPK_FWD;
      OP_PCM_WR, OP_ENC_WR: return OPK_STREAM;
      default:              return OPK_BAD;
    endcase
  endfunction
endpackage

// File: rtl/hcf_spi_shifter.sv
module hcf_spi_shifter #(
  parameter int W     = 8,
  parameter int SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic [W-1:0] tx_word,
  output logic         miso,
  output logic         sel,
  output logic         rx_done,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(W);

  logic [SYNC-1:0] sck_p, cs_p, mosi_p;
  logic            sck_d, cs_d;
  logic            sck_s, cs_s, mosi_s;
  logic            rise, fall, sel_start;
  logic [CW-1:0]   bit_q, bit_n;
  logic [W-1:0]    rx_q, rx_n, tx_q, tx_n;
  logic            done_q, done_n;

  assign sck_s     = sck_p[SYNC-1];
  assign cs_s      = cs_p[SYNC-1];
  assign mosi_s    = mosi_p[SYNC-1];
  assign sel       = ~cs_s;
  assign rise      = sel & sck_s & ~sck_d;
  assign fall      = sel & ~sck_s & sck_d;
  assign sel_start = ~cs_s & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_p  <= {sck_p[SYNC-2:0], sck};
      cs_p   <= {cs_p[SYNC-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  always_comb begin
    bit_n  = bit_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    done_n = 1'b0;
    if (!sel) begin
      bit_n = '0;
    end else if (rise) begin
      rx_n = {rx_q[W-2:0], mosi_s};
      if (bit_q == CW'(W-1)) begin
        bit_n  = '0;
        done_n = 1'b1;
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end
    if (sel_start || (fall && bit_q == '0)) tx_n = tx_word;
    else if (fall)                          tx_n = {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      done_q <= done_n;
    end
  end

  assign miso    = tx_q[W-1];
  assign rx_done = done_q;
  assign rx_word = rx_q;

  // R12: a completed byte can only come out of a selected transaction
  p_done_needs_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(sel));
endmodule

// File: rtl/hcf_irq_flags.sv
module hcf_irq_flags #(
  parameter int          N    = 8,
  parameter logic [N-1:0] MASK = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq_n
);
  logic [N-1:0] flags_q, flags_n;

  always_comb flags_n = (flags_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_n;
  end

  assign flags = flags_q;
  assign irq_n = ~|(flags_q & MASK);

  // R8: a flag can only drop after a read-interrupt clear request
  p_clear_only_by_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_q) & ~flags_q)) |-> $past(|clr));
endmodule

// File: rtl/hcf_cmd_ctrl.sv
module hcf_cmd_ctrl
  import hcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_word,
  input  logic [BYTE_W-1:0] flags,
  input  logic              sink_ready,
  input  logic              exec_done,
  input  logic              exec_busy,
  input  logic              st_full,
  input  logic              st_vg_busy,
  input  logic              st_cbuf_full,
  output logic [BYTE_W-1:0] tx_word,
  output logic [BYTE_W-1:0] flag_set,
  output logic [BYTE_W-1:0] flag_clr,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_op,
  output logic              opnd_valid,
  output logic [BYTE_W-1:0] opnd_data
);
  opk_e              kind;
  logic              pd_q, pd_n;
  logic              first_q, first_n;
  ctx_e              ctx_q, ctx_n;
  logic              strm_q, strm_n;
  logic [BYTE_W-1:0] snap_q, snap_n;
  logic              cv_q, cv_n, ov_q, ov_n;
  logic [BYTE_W-1:0] op_q, op_n, od_q, od_n;
  logic [BYTE_W-1:0] status;

  assign kind   = classify(rx_word);
  assign status = {pd_q, sink_ready & ~pd_q, |flags, st_full, 1'b0,
                   st_vg_busy, st_cbuf_full, exec_busy};
  assign tx_word = (ctx_q == CTX_RDINT && !first_q) ? snap_q : status;

  always_comb begin
    pd_n = pd_q;  first_n = first_q; ctx_n = ctx_q; strm_n = strm_q;
    snap_n = snap_q; op_n = op_q; od_n = od_q;
    cv_n = 1'b0; ov_n = 1'b0;
    flag_set = '0; flag_clr = '0;
    if (!sel) begin
      first_n = 1'b1;
      ctx_n   = CTX_NONE;
    end else if (rx_done) begin
      first_n = 1'b0;
      if (first_q) begin
        ctx_n = CTX_NONE;
        if (kind == OPK_RDINT) begin
          ctx_n  = CTX_RDINT;
          snap_n = flags;
        end else if (pd_q) begin
          if (kind == OPK_PUP) begin
            pd_n = 1'b0;
            flag_set[FLAG_FIN] = 1'b1;
          end
        end else begin
          unique case (kind)
            OPK_PUP, OPK_BAD: flag_set[FLAG_ERR] = 1'b1;
            OPK_PDN: begin
              pd_n = 1'b1;
              flag_set[FLAG_FIN] = 1'b1;
            end
            OPK_FWD, OPK_STREAM: begin
              cv_n   = 1'b1;
              op_n   = rx_word;
              ctx_n  = CTX_FWD;
              strm_n = (kind == OPK_STREAM);
            end
            default: ;
          endcase
        end
      end else if (ctx_q == CTX_FWD) begin
        if (sink_ready) begin
          ov_n = 1'b1;
          od_n = rx_word;
        end else if (strm_q) begin
          flag_set[FLAG_OVF] = 1'b1;
        end
      end else if (ctx_q == CTX_RDINT) begin
        flag_clr = snap_q;
        ctx_n    = CTX_NONE;
      end
    end
    if (exec_done) flag_set[FLAG_FIN] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b1; first_q <= 1'b1; ctx_q <= CTX_NONE; strm_q <= 1'b0;
      snap_q <= '0; cv_q <= 1'b0; ov_q <= 1'b0; op_q <= '0; od_q <= '0;
    end else begin
      pd_q <= pd_n; first_q <= first_n; ctx_q <= ctx_n; strm_q <= strm_n;
      snap_q <= snap_n; cv_q <= cv_n; ov_q <= ov_n; op_q <= op_n; od_q <= od_n;
    end
  end

  assign cmd_valid  = cv_q;
  assign cmd_op     = op_q;
  assign opnd_valid = ov_q;
  assign opnd_data  = od_q;

  p_pd_no_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && rx_done && first_q) |=> !cmd_valid);
  p_pd_no_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && rx_done && first_q) |=> (flags[FLAG_ERR] == $past(flags[FLAG_ERR])));
  p_opnd_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid |-> $past(sink_ready));
  p_stream_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !first_q && ctx_q == CTX_FWD && strm_q && !sink_ready)
      |=> flags[FLAG_OVF]);
endmodule

// File: rtl/hostcmd_front.sv
module hostcmd_front #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] IRQ_MASK    = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       rdy_o,
  output logic       irq_n_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_op_o,
  output logic       opnd_valid_o,
  output logic [7:0] opnd_data_o,
  input  logic       sink_ready_i,
  input  logic       exec_done_i,
  input  logic       exec_busy_i,
  input  logic       st_full_i,
  input  logic       st_vg_busy_i,
  input  logic       st_cbuf_full_i
);
  import hcf_pkg::*;

  logic              sel, rx_done;
  logic [BYTE_W-1:0] rx_word, tx_word, flags, flag_set, flag_clr;

  hcf_spi_shifter #(.W(BYTE_W), .SYNC(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word), .miso(spi_miso), .sel(sel), .rx_done(rx_done),
    .rx_word(rx_word));

  hcf_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rx_done(rx_done), .rx_word(rx_word),
    .flags(flags), .sink_ready(sink_ready_i), .exec_done(exec_done_i),
    .exec_busy(exec_busy_i), .st_full(st_full_i), .st_vg_busy(st_vg_busy_i),
    .st_cbuf_full(st_cbuf_full_i), .tx_word(tx_word), .flag_set(flag_set),
    .flag_clr(flag_clr), .cmd_valid(cmd_valid_o), .cmd_op(cmd_op_o),
    .opnd_valid(opnd_valid_o), .opnd_data(opnd_data_o));

  hcf_irq_flags #(.N(BYTE_W), .MASK(IRQ_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
    .flags(flags), .irq_n(irq_n_o));

  assign rdy_o = sink_ready_i;
endmodule

// File: tb/hostcmd_front_test.sv
module hostcmd_front_test;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic sink_ready = 1'b1, exec_done = 1'b0, exec_busy = 1'b0;
  logic st_full = 1'b0, st_vg = 1'b0, st_cbf = 1'b0;
  logic spi_miso, rdy, irq_n, cmd_valid, opnd_valid;
  logic [7:0] cmd_op, opnd_data;

  int n_tests = 0, n_fail = 0, fwd_cnt = 0, opn_cnt = 0;
  logic [7:0] last_op = 8'h00, last_opnd = 8'h00;
  logic exp_pd = 1'b1;
  logic [7:0] exp_flags = 8'h00;
  int exp_fwd = 0, exp_opn = 0;
  bit finished = 0;

  hostcmd_front uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rdy_o(rdy), .irq_n_o(irq_n),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .opnd_valid_o(opnd_valid),
    .opnd_data_o(opnd_data), .sink_ready_i(sink_ready), .exec_done_i(exec_done),
    .exec_busy_i(exec_busy), .st_full_i(st_full), .st_vg_busy_i(st_vg),
    .st_cbuf_full_i(st_cbf));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (cmd_valid)  begin fwd_cnt <= fwd_cnt + 1; last_op <= cmd_op; end
    if (opnd_valid) begin opn_cnt <= opn_cnt + 1; last_opnd <= opnd_data; end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {exp_pd, sink_ready & ~exp_pd, |exp_flags, st_full, 1'b0, st_vg, st_cbf, exec_busy};
  endfunction

  task automatic sel_on();  spi_cs_n = 1'b0; wait_clk(HALF); endtask
  task automatic sel_off(); wait_clk(HALF); spi_cs_n = 1'b1; wait_clk(2*HALF); endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = d[i];
      wait_clk(HALF);
      r[i] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xact(input logic [7:0] op, input bit two, input logic [7:0] b1,
                      output logic [7:0] s0, output logic [7:0] s1);
    s1 = 8'h00;
    sel_on();
    xbyte(op, s0);
    if (two) xbyte(b1, s1);
    sel_off();
  endtask

  task automatic pulse_done();
    exec_done = 1'b1; wait_clk(1); exec_done = 1'b0; wait_clk(2);
  endtask

  // Bench model of R4/R5/R6/R9 for one opcode (read-interrupt handled apart)
  task automatic model_cmd(input logic [7:0] op, input bit has_opnd);
    if (op == 8'h40) return;
    if (exp_pd) begin
      if (op == 8'h10) begin exp_pd = 1'b0; exp_flags[0] = 1'b1; end
      return;
    end
    case (op)
      8'h10: exp_flags[1] = 1'b1;
      8'h12: begin exp_pd = 1'b1; exp_flags[0] = 1'b1; end
      8'h2A, 8'hAE, 8'hAA, 8'hC0: begin
        exp_fwd++;
        if (has_opnd) begin
          if (sink_ready) exp_opn++;
          else if (op == 8'hAA || op == 8'hC0) exp_flags[2] = 1'b1;
        end
      end
      default: exp_flags[1] = 1'b1;
    endcase
  endtask

  task automatic run_cmd(input string req, input logic [7:0] op, input bit two,
                         input logic [7:0] b1);
    logic [7:0] s0, s1;
    logic [7:0] es = exp_status();
    xact(op, two, b1, s0, s1);
    chk(req, s0, es, "status byte");
    model_cmd(op, two);
    chk(req, fwd_cnt, exp_fwd, "forward count");
    chk(req, opn_cnt, exp_opn, "operand count");
  endtask

  task automatic read_int(input string req);
    logic [7:0] s0, s1;
    logic [7:0] es = exp_status();
    xact(8'h46, 1'b1, 8'h00, s0, s1);
    chk(req, s0, es, "status before flag byte");
    chk(req, s1, exp_flags, "flag byte");
    exp_flags = 8'h00;
    chk(req, irq_n, 1, "irq released after read");
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    finished = 1;
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    logic [7:0] s0, s1, dummy;
    logic [7:0] pool [7];
    void'($urandom(32'h1234_5678));
    pool = '{8'h10, 8'h12, 8'h2A, 8'hAE, 8'hAA, 8'h40, 8'h77};
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R3: reset state
    chk("R3", irq_n, 1, "irq after reset");
    chk("R3", rdy, 1, "rdy follows sink");
    run_cmd("R3", 8'h40, 1'b0, 8'h00);

    // R4: powered-down filtering, silent drops
    run_cmd("R4", 8'h2A, 1'b0, 8'h00);
    run_cmd("R4", 8'hAA, 1'b1, 8'h33);
    run_cmd("R4", 8'h77, 1'b0, 8'h00);
    chk("R4", irq_n, 1, "no error raised while down");

    // R5 / R11: power up
    run_cmd("R5", 8'h10, 1'b0, 8'h00);
    chk("R11", irq_n, 0, "irq asserted on finished");
    read_int("R7");
    run_cmd("R5", 8'h10, 1'b0, 8'h00);
    run_cmd("R6", 8'h77, 1'b0, 8'h00);
    read_int("R6");

    // R1: forwarding
    run_cmd("R1", 8'h2A, 1'b0, 8'h00);
    chk("R1", last_op, 8'h2A, "forwarded opcode");
    run_cmd("R1", 8'hAE, 1'b1, 8'h05);
    chk("R1", last_op, 8'hAE, "forwarded opcode");
    chk("R1", last_opnd, 8'h05, "forwarded operand");

    // R9: streaming while not ready
    sink_ready = 1'b0;
    wait_clk(1);
    chk("R9", rdy, 0, "rdy low");
    sel_on();
    xbyte(8'hAA, s0);
    xbyte(8'h11, s1);
    chk("R9", s1[6], 0, "ready bit on refused byte");
    xbyte(8'h22, dummy);
    sel_off();
    exp_fwd++; exp_flags[2] = 1'b1;
    chk("R9", opn_cnt, exp_opn, "no operand accepted");
    sink_ready = 1'b1;
    read_int("R9");

    // R10
    pulse_done();
    exp_flags[0] = 1'b1;
    chk("R10", irq_n, 0, "irq on exec done");
    read_int("R10");

    // R7/R8: flag raised after snapshot survives the clear
    sink_ready = 1'b0;
    run_cmd("R9", 8'hAA, 1'b1, 8'h44);
    sink_ready = 1'b1;
    sel_on();
    xbyte(8'h46, s0);
    pulse_done();
    xbyte(8'h00, s1);
    sel_off();
    chk("R7", s1, 8'h04, "snapshot flag byte");
    chk("R7", irq_n, 0, "late flag still pending");
    exp_flags = 8'h01;
    run_cmd("R8", 8'h40, 1'b0, 8'h00);
    read_int("R8");

    // R12: select raised mid-byte
    sel_on();
    for (int i = 7; i >= 4; i--) begin
      spi_mosi = 1'(8'hAA >> i);
      wait_clk(HALF); spi_sck = 1'b1; wait_clk(HALF); spi_sck = 1'b0;
    end
    sel_off();
    run_cmd("R12", 8'h2A, 1'b0, 8'h00);
    chk("R12", last_op, 8'h2A, "clean opcode after abort");

    // R2: status field positions
    st_full = 1'b1; st_vg = 1'b1; exec_busy = 1'b1;
    run_cmd("R2", 8'h40, 1'b0, 8'h00);
    st_full = 1'b0; st_cbf = 1'b1; exec_busy = 1'b0; st_vg = 1'b0;
    run_cmd("R2", 8'h40, 1'b0, 8'h00);
    st_cbf = 1'b0;

    // R4: power down then read-interrupt still honoured
    run_cmd("R5", 8'h12, 1'b0, 8'h00);
    read_int("R4");

    // Constrained random
    for (int it = 0; it < 60; it++) begin
      logic [7:0] op = pool[$urandom_range(0, 6)];
      sink_ready = 1'($urandom_range(0, 1));
      wait_clk(1);
      chk("R9", rdy, sink_ready, "rdy follows sink");
      run_cmd("R4", op, (op == 8'hAA || op == 8'hAE), 8'($urandom_range(0, 255)));
      if (it % 5 == 4) read_int("R7");
    end

    finish_up();
  end
endmodule